// File: doc/BRIEF.md
# Layer-Multiplexed Perceptron Inference Engine

This block evaluates a fixed 4-3-2 multilayer perceptron: four signed fixed-point features go in, three hidden neurons and two output neurons are evaluated, and two activations come out. A layer does not get one datapath per neuron. It gets one multiply-accumulate neuron that computes each of its neurons in turn. A per-layer sequencer reads coefficient vectors from constant on-chip storage and feeds them to the shared neuron in step with it. When the hidden sequencer finishes, it passes an enable to the output sequencer.

A one-cycle start pulse captures the features and begins a run. The hidden activations go into a three-entry register file. The output sequencer's tap index then selects which entry feeds the output neuron, and the result index of the output neuron selects which output slot is written. The done flag pulses for one cycle when both outputs are valid. Both outputs keep their values until a later run overwrites them.

Top module: `mlp_engine`

## Requirements
- R1: Each neuron forms the full-precision sum of products of its Q4.12 inputs and Q4.12 weights, then adds its Q4.12 bias shifted left by 12. It shifts the result right arithmetically by 12 (floor) and saturates it to the signed 16-bit range [-32768, 32767].
- R2: The activation of a saturated sum s is a 256-entry table indexed by k = (s + 32768) >> 8. Each entry uses x = k*256 - 32768, with a = |x| in Q4.12. The positive part p, in Q0.16, is: 65536 for a >= 20480; a/2 + 55296 for a >= 9728; 2a + 40960 for a >= 4096; 4a + 32768 otherwise. The entry is p for x >= 0 and 65536 - p for x < 0, and is clamped to at most 65535.
- R3: The coefficients are fixed. Hidden neuron j, input i, has weight (((4j+i) mod 5) - 2)*1024 and bias (j-1)*2048. Output neuron k, hidden input j, has weight ((((3k+j) mod 4)*2) - 3)*2048 and bias 2048k - 1024. The output layer takes as input each hidden activation shifted right by 4, which is its Q4.12 value.
- R4: Hidden neurons are evaluated in the order 0, 1, 2, and the output layer begins only after the hidden layer has finished. Output 0 is written first: it becomes visible 21 clock edges after the start-sampling edge, while output 1 still holds its previous value until edge 25.
- R5: done_o goes high after the 25th rising edge that follows the edge sampling an accepted start, and stays high for exactly one cycle.
- R6: A start pulse that arrives while a run is in progress is ignored. It does not change the results, the done timing, or the number of done pulses.
- R7: The features are captured on the edge that accepts start. Feature changes during a run have no effect on that run.
- R8: Asynchronous reset clears both outputs, the done flag and the hidden register file, and returns both sequencers to idle. A start after reset runs normally.
- R9: Between runs, both outputs hold their values and done stays low, whatever the features do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| feat_i | input | 64 | Four Q4.12 features, feature i at bits [16i+15:16i] |
| act_o | output | 32 | Two Q0.16 activations, output k at bits [16k+15:16k] |
| done_o | output | 1 | One-cycle pulse when both outputs are valid |

## Verification
The features are tried with an all-zero vector, mixed-sign vectors and an all-negative-leaning vector. The zero vector isolates the bias terms and the hidden-to-output conversion. The mixed vectors test the weight pattern and the order in which inputs are routed. Two extreme vectors push a hidden sum into positive and then negative saturation, which separates correct clamping from a wrapped sum. Timing-oriented runs look at the ports on exact cycles: output 0 updating before output 1, done on edge 25 only, a second start mid-run, features changing mid-run, an idle period and a reset in the middle of a run.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  localparam int DW    = 16;  // Q4.12 data width
  localparam int FRAC  = 12;
  localparam int AW    = 16;  // Q0.16 activation width
  localparam int LUT_W = 8;

  typedef logic signed [DW-1:0] fix_t;
  typedef logic [AW-1:0]        act_t;

  // piecewise sigmoid sampled at the lower edge of table bin k
  function automatic act_t sig_entry(int k);
    int x, a, y;
    x = (k * (1 << (DW - LUT_W))) - (1 << (DW - 1));
    a = (x < 0) ? -x : x;
    if (a >= (5 << FRAC))             y = 1 << AW;
    else if (a >= ((19 << FRAC) / 8)) y = (a * (1 << AW)) / (32 << FRAC) + (27 * (1 << AW)) / 32;
    else if (a >= (1 << FRAC))        y = (a * (1 << AW)) / (8 << FRAC) + (5 * (1 << AW)) / 8;
    else                              y = (a * (1 << AW)) / (4 << FRAC) + (1 << AW) / 2;
    if (x < 0) y = (1 << AW) - y;
    if (y > (1 << AW) - 1) y = (1 << AW) - 1;
    return act_t'(y);
  endfunction

  // tap == fan_in selects the bias
  function automatic fix_t coef(bit is_out, int n, int t, int fan_in);
    int v;
    if (!is_out)
      v = (t == fan_in) ? (n - 1) * (1 << (FRAC - 1))
                        : (((n * fan_in + t) % 5) - 2) * (1 << (FRAC - 2));
    else
      v = (t == fan_in) ? n * (1 << (FRAC - 1)) - (1 << (FRAC - 2))
                        : ((((n * fan_in + t) % 4) * 2) - 3) * (1 << (FRAC - 1));
    return fix_t'(v);
  endfunction
endpackage

// File: rtl/mlp_sigmoid.sv
module mlp_sigmoid
  import mlp_pkg::*;
(
  input  fix_t sum_i,
  output act_t act_o
);
  localparam int ENTRIES = 1 << LUT_W;

  act_t             rom [ENTRIES];
  logic [LUT_W-1:0] idx;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_rom
    assign rom[k] = sig_entry(k);
  end

  // (s + 2^(DW-1)) >> (DW-LUT_W): flip the sign bit of the top slice
  assign idx   = {~sum_i[DW-1], sum_i[DW-2 -: LUT_W-1]};
  assign act_o = rom[idx];
endmodule

// File: rtl/mlp_neuron.sv
module mlp_neuron
  import mlp_pkg::*;
#(
  parameter int N_IN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic first_i,
  input  logic bias_step_i,
  input  fix_t x_i,
  input  fix_t coef_i,
  output act_t act_o,
  output logic vld_o
);
  localparam int ACC_W = 2 * DW + $clog2(N_IN + 1) + 1;
  localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((1 << (DW - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SMIN = ~SMAX;

  logic signed [2*DW-1:0]  prod;
  logic signed [ACC_W-1:0] prod_ext, bias_ext, acc_q, tot, shd;
  fix_t                    sat, sum_q;
  logic                    vld_q;

  assign prod     = x_i * coef_i;
  assign prod_ext = {{(ACC_W-2*DW){prod[2*DW-1]}}, prod};
  assign bias_ext = {{(ACC_W-DW){coef_i[DW-1]}}, coef_i};
  assign tot      = acc_q + (bias_ext <<< FRAC);
  assign shd      = tot >>> FRAC;

  always_comb begin
    if (shd > SMAX)      sat = fix_t'(SMAX);
    else if (shd < SMIN) sat = fix_t'(SMIN);
    else                 sat = fix_t'(shd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (step_i) acc_q <= first_i ? prod_ext : acc_q + prod_ext;
      if (bias_step_i) sum_q <= sat;
      vld_q <= bias_step_i;
    end
  end

  mlp_sigmoid u_sig (.sum_i(sum_q), .act_o(act_o));

  assign vld_o = vld_q;

  AST_STEP_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i && bias_step_i)); // R1
endmodule

// File: rtl/mlp_layer_seq.sv
module mlp_layer_seq
  import mlp_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_NEU  = 3,
  parameter bit IS_OUT = 1'b0,
  localparam int TAP_W = $clog2(N_IN + 1),
  localparam int NEU_W = (N_NEU > 1) ? $clog2(N_NEU) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic             run_o,
  output logic [TAP_W-1:0] tap_o,
  output logic             step_o,
  output logic             first_o,
  output logic             bias_step_o,
  output fix_t             coef_o,
  output logic [NEU_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(N_IN);
  localparam logic [NEU_W-1:0] NEU_LAST = NEU_W'(N_NEU - 1);

  fix_t             rom [N_NEU][N_IN+1];
  logic             run_q, last_q;
  logic [TAP_W-1:0] tap_q;
  logic [NEU_W-1:0] neu_q, idx_q;
  logic             at_bias;

  for (genvar n = 0; n < N_NEU; n++) begin : g_neu
    for (genvar t = 0; t <= N_IN; t++) begin : g_tap
      assign rom[n][t] = coef(IS_OUT, n, t, N_IN);
    end
  end

  assign at_bias = run_q && (tap_q == TAP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      tap_q  <= '0;
      neu_q  <= '0;
      idx_q  <= '0;
      last_q <= 1'b0;
    end else begin
      last_q <= at_bias && (neu_q == NEU_LAST);
      if (at_bias) idx_q <= neu_q;
      if (en_i && !run_q) begin
        run_q <= 1'b1;
        tap_q <= '0;
        neu_q <= '0;
      end else if (run_q) begin
        if (at_bias) begin
          tap_q <= '0;
          if (neu_q == NEU_LAST) begin
            run_q <= 1'b0;
            neu_q <= '0;
          end else begin
            neu_q <= neu_q + NEU_W'(1);
          end
        end else begin
          tap_q <= tap_q + TAP_W'(1);
        end
      end
    end
  end

  assign run_o       = run_q;
  assign tap_o       = tap_q;
  assign step_o      = run_q && (tap_q != TAP_LAST);
  assign first_o     = (tap_q == '0);
  assign bias_step_o = at_bias;
  assign coef_o      = rom[neu_q][tap_q];
  assign idx_o       = idx_q;
  assign last_o      = last_q;

  AST_EN_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> !run_q); // R6
  AST_NEURON_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_bias && neu_q != NEU_LAST) |=> (run_q && tap_q == '0 && neu_q == $past(neu_q) + NEU_W'(1))); // R4
endmodule

// File: rtl/mlp_engine.sv
module mlp_engine
  import mlp_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_HID = 3,
  parameter int N_OUT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_IN*DW-1:0] feat_i,
  output logic [N_OUT*AW-1:0] act_o,
  output logic               done_o
);
  localparam int HT_W = $clog2(N_IN + 1);
  localparam int OT_W = $clog2(N_HID + 1);
  localparam int HI_W = (N_HID > 1) ? $clog2(N_HID) : 1;
  localparam int OI_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;

  logic [N_IN-1:0][DW-1:0] x_q;
  act_t                    hid_rf [N_HID];
  act_t                    act_q  [N_OUT];
  logic                    busy_q, done_q, accept;

  logic            hid_run, hid_step, hid_first, hid_bias, hid_last, hid_vld;
  logic [HT_W-1:0] hid_tap;
  logic [HI_W-1:0] hid_idx;
  fix_t            hid_coef, hid_x;
  act_t            hid_act;

  logic            out_run, out_step, out_first, out_bias, out_last, out_vld;
  logic [OT_W-1:0] out_tap;
  logic [OI_W-1:0] out_idx;
  fix_t            out_coef, out_x;
  act_t            out_act, sel_rf;

  assign accept = start_i && !busy_q;

  // feature select for the hidden neuron
  always_comb begin
    hid_x = '0;
    for (int i = 0; i < N_IN; i++)
      if (hid_tap == HT_W'(i)) hid_x = fix_t'(x_q[i]);
  end

  // hidden register file select for the output neuron, Q0.16 -> Q4.12
  always_comb begin
    sel_rf = '0;
    for (int j = 0; j < N_HID; j++)
      if (out_tap == OT_W'(j)) sel_rf = hid_rf[j];
  end
  assign out_x = fix_t'(sel_rf >> (AW - FRAC));

  mlp_layer_seq #(.N_IN(N_IN), .N_NEU(N_HID), .IS_OUT(1'b0)) u_hid_seq (
    .clk_i, .rst_ni, .en_i(accept), .run_o(hid_run), .tap_o(hid_tap),
    .step_o(hid_step), .first_o(hid_first), .bias_step_o(hid_bias),
    .coef_o(hid_coef), .idx_o(hid_idx), .last_o(hid_last)
  );

  mlp_neuron #(.N_IN(N_IN)) u_hid_neuron (
    .clk_i, .rst_ni, .step_i(hid_step), .first_i(hid_first), .bias_step_i(hid_bias),
    .x_i(hid_x), .coef_i(hid_coef), .act_o(hid_act), .vld_o(hid_vld)
  );

  mlp_layer_seq #(.N_IN(N_HID), .N_NEU(N_OUT), .IS_OUT(1'b1)) u_out_seq (
    .clk_i, .rst_ni, .en_i(hid_last), .run_o(out_run), .tap_o(out_tap),
    .step_o(out_step), .first_o(out_first), .bias_step_o(out_bias),
    .coef_o(out_coef), .idx_o(out_idx), .last_o(out_last)
  );

  mlp_neuron #(.N_IN(N_HID)) u_out_neuron (
    .clk_i, .rst_ni, .step_i(out_step), .first_i(out_first), .bias_step_i(out_bias),
    .x_i(out_x), .coef_i(out_coef), .act_o(out_act), .vld_o(out_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      for (int j = 0; j < N_HID; j++) hid_rf[j] <= '0;
      for (int k = 0; k < N_OUT; k++) act_q[k]  <= '0;
    end else begin
      done_q <= out_last;
      if (accept) begin
        busy_q <= 1'b1;
        x_q    <= feat_i;
      end else if (out_last) begin
        busy_q <= 1'b0;
      end
      if (hid_vld) hid_rf[hid_idx] <= hid_act;
      if (out_vld) act_q[out_idx]  <= out_act;
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_act
    assign act_o[k*AW +: AW] = act_q[k];
  end
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_q && !hid_run && !out_run)); // R5
  AST_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_run) |-> $past(hid_last)); // R4
  AST_FEAT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(x_q)); // R7
endmodule

// File: tb/mlp_engine_tb_top.sv
module mlp_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] feat = '0;
  logic [31:0] act;
  logic        done;
  int          checks = 0;
  int          errors = 0;

  mlp_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .feat_i(feat),
    .act_o(act), .done_o(done)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  // reference model from the requirements
  function automatic int w_hid(int j, int i); return (((4*j + i) % 5) - 2) * 1024; endfunction
  function automatic int b_hid(int j); return (j - 1) * 2048; endfunction
  function automatic int w_out(int k, int j); return ((((3*k + j) % 4) * 2) - 3) * 2048; endfunction
  function automatic int b_out(int k); return 2048*k - 1024; endfunction

  function automatic int sat_ref(longint acc);
    longint q;
    q = acc >>> 12;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  function automatic int sig_ref(int s);
    int k, x, a, p;
    k = (s + 32768) / 256;
    x = k * 256 - 32768;
    a = (x < 0) ? -x : x;
    if (a >= 20480)     p = 65536;
    else if (a >= 9728) p = a / 2 + 55296;
    else if (a >= 4096) p = 2 * a + 40960;
    else                p = 4 * a + 32768;
    if (x < 0) p = 65536 - p;
    if (p > 65535) p = 65535;
    return p;
  endfunction

  function automatic logic [31:0] model(input logic [63:0] f);
    int h [3];
    longint acc;
    logic [31:0] r;
    for (int j = 0; j < 3; j++) begin
      acc = longint'(b_hid(j)) * 4096;
      for (int i = 0; i < 4; i++)
        acc += longint'($signed(f[i*16 +: 16])) * longint'(w_hid(j, i));
      h[j] = sig_ref(sat_ref(acc));
    end
    for (int k = 0; k < 2; k++) begin
      acc = longint'(b_out(k)) * 4096;
      for (int j = 0; j < 3; j++)
        acc += longint'(h[j] >> 4) * longint'(w_out(k, j));
      r[k*16 +: 16] = 16'(sig_ref(sat_ref(acc)));
    end
    return r;
  endfunction

  task automatic launch(input logic [63:0] f);
    @(negedge clk);
    feat  = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // full run with order and latency checks; n counts edges after the start edge
  task automatic run_check(input logic [63:0] f, input string tag);
    logic [31:0] e, prev;
    bit early;
    e = model(f);
    prev = act;
    early = 1'b0;
    launch(f);
    for (int n = 1; n <= 25; n++) begin
      @(negedge clk);
      if (n == 22)
        chk(act[15:0] == e[15:0] && act[31:16] == prev[31:16], "R4 output 0 before output 1",
            act, {prev[31:16], e[15:0]});
      if (n < 25 && done) early = 1'b1;
      if (n == 25) chk(done && !early, "R5 done on edge 25", {31'd0, done}, 32'd1);
    end
    chk(act == e, tag, act, e);
    @(negedge clk);
    chk(!done, "R5 done single cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(act == 32'd0 && !done, "R8 reset state", act, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_patterns;
    run_check(64'h0, "R1,R3 zero features");
    run_check({16'h3000, 16'h0800, 16'hE000, 16'h1000}, "R1,R3 mixed features");
    run_check({16'hD800, 16'h2000, 16'hF000, 16'hC000}, "R1,R2 negative-leaning features");
    run_check({16'h1800, 16'hF800, 16'h2400, 16'h0400}, "R2,R3 fractional features");
  endtask

  task automatic t_saturate;
    run_check({16'h0000, 16'h8000, 16'h8000, 16'h7FFF}, "R1 positive saturation");
    run_check({16'h0000, 16'h7FFF, 16'h7FFF, 16'h8000}, "R1 negative saturation");
  endtask

  task automatic t_busy_start;
    logic [63:0] a_f, b_f;
    logic [31:0] e, held;
    int dcount;
    a_f = {16'h2000, 16'hF000, 16'h0C00, 16'hE800};
    b_f = {16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF};
    e = model(a_f);
    dcount = 0;
    launch(a_f);
    for (int n = 1; n <= 25; n++) begin
      @(negedge clk);
      if (n == 10) begin feat = b_f; start = 1'b1; end
      if (n == 11) start = 1'b0;
      if (done) dcount++;
      if (n == 25) chk(done, "R6 done timing with extra start", {31'd0, done}, 32'd1);
    end
    chk(act == e, "R6 extra start ignored", act, e);
    held = act;
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (done) dcount++;
    end
    chk(dcount == 1, "R6 single done pulse", 32'(dcount), 32'd1);
    chk(act == held, "R6 outputs unchanged after ignored start", act, held);
  endtask

  task automatic t_feat_change;
    logic [63:0] a_f;
    logic [31:0] e;
    a_f = {16'hF400, 16'h1C00, 16'h0600, 16'hDC00};
    e = model(a_f);
    launch(a_f);
    for (int n = 1; n <= 25; n++) begin
      @(negedge clk);
      if (n == 3) feat = ~a_f;
    end
    chk(done, "R7 done with changing features", {31'd0, done}, 32'd1);
    chk(act == e, "R7 features captured at start", act, e);
  endtask

  task automatic t_hold;
    logic [31:0] held;
    bit seen;
    held = act;
    seen = 1'b0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      feat = feat + 64'h0001_0203_0405_0607;
      if (done) seen = 1'b1;
    end
    chk(act == held, "R9 outputs hold while idle", act, held);
    chk(!seen, "R9 no done while idle", {31'd0, seen}, 32'd0);
  endtask

  task automatic t_mid_reset;
    launch({16'h1000, 16'h1000, 16'h1000, 16'h1000});
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(act == 32'd0 && !done, "R8 reset during run", act, 32'd0);
    rst_n = 1'b1;
    run_check({16'hE000, 16'h3000, 16'h0400, 16'hF800}, "R8 run after reset");
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_saturate();
    t_busy_start();
    t_feat_change();
    t_hold();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired (R5 no completion) actual=hang expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule